// File: doc/BRIEF.md
# Crossbar Memory Barrier Propagator

This block sits between one requesting master and a set of target paths inside a small crossbar. It enforces ordering barriers. Ordinary read and write requests are steered to one target path by a single address field. A barrier uses the same request channel, with no data and a zero address. Two type bits mark the request as a weak or a strong barrier, and the request carries an identifier.

When the master interface accepts a barrier, it hands the barrier to every target path at the same time. Each path keeps a count of writes that its target has accepted but not yet completed. A path answers the barrier only once that count has drained to zero, so a barrier never overtakes earlier writes on its path. While any path answer is still outstanding, the master interface holds every further request from the master. Other paths of the chip keep running.

The barrier type decides only when the master receives its barrier response. A weak barrier gets its response at once, so the master may queue its next request, which is then held at the master interface. A strong barrier gets its response only after all paths have answered.

Top module: `bar_prop`

## Requirements
- R1: The two barrier bits `m_bar` encode 2'b00 as an ordinary request, 2'b01 as a weak barrier and 2'b11 as a strong barrier. The reserved code 2'b10 is handled exactly like 2'b00.
- R2: An ordinary request goes only to the path whose index equals `m_addr[SEL_LSB]` (one select bit with two paths). It raises that path's `s_valid` bit and no other. While no barrier is outstanding, `m_ready` follows that path's `s_ready`.
- R3: A weak barrier produces a one-cycle `m_bresp_valid` in the cycle after it is accepted. `m_bresp_id` carries the barrier's identifier.
- R4: An accepted barrier is delivered to every path. A path with no uncompleted writes answers in the cycle after acceptance.
- R5: A path with uncompleted writes answers only in the cycle after its count of accepted but uncompleted writes returns to zero. The count rises on each write handshake (`s_valid` and `s_ready` with `m_write`) and falls on each pulse of that path's `s_done` bit.
- R6: From the edge that accepts a barrier until the edge after the last path answer, `m_ready` is low and no `s_valid` bit is raised. In the cycle after that edge, requests flow again.
- R7: A strong barrier raises `m_bresp_valid` for one cycle, in the cycle after the last path answer, and never earlier.
- R8: A second barrier is not accepted while an earlier one still awaits path answers.
- R9: An active-low reset asynchronously clears all pending barrier state and write counts, so no request is blocked afterwards. Its release takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Master request accepted this cycle |
| m_write | input | 1 | Request is a write |
| m_bar | input | 2 | Barrier type bits |
| m_id | input | IW | Request identifier |
| m_addr | input | AW | Request address (path select field at SEL_LSB) |
| m_bresp_valid | output | 1 | Barrier response pulse to the master |
| m_bresp_id | output | IW | Identifier of the answered barrier |
| s_valid | output | NS | Per-path request valid |
| s_ready | input | NS | Per-path request accept |
| s_write | output | 1 | Forwarded write flag |
| s_id | output | IW | Forwarded identifier |
| s_addr | output | AW | Forwarded address |
| s_done | input | NS | Per-path write completion pulse |

## Verification
The hardest case to reach is a barrier that is waiting on two paths at once, with their writes draining at different times. Each path must answer on its own, and the master may try to send more requests while the barrier waits. The stimulus builds this up first: it sends one accepted write to each path, issues the barrier, keeps a request pending against the block, and then completes the two writes in separate cycles. It watches the block stay closed until the second answer, and checks the exact cycle in which it opens again. A reset is also asserted in the middle of such a wait, to show that counts and pending state are cleared.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BK_NORM   = 2'b00,
    BK_WEAK   = 2'b01,
    BK_RSVD   = 2'b10,
    BK_STRONG = 2'b11
  } bar_kind_e;

  function automatic logic is_barrier(input logic [1:0] kind);
    return kind[0];
  endfunction

  function automatic logic is_strong(input logic [1:0] kind);
    return kind == BK_STRONG;
  endfunction
endpackage

// File: rtl/bp_slv_path.sv
module bp_slv_path #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic wr_done,
  input  logic bar_set,
  output logic ans
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          dec;

  assign ans = flag_q && (cnt_q == '0);
  assign dec = wr_done && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_fire && !dec)      cnt_d = cnt_q + 1'b1;
    else if (!wr_fire && dec) cnt_d = cnt_q - 1'b1;
    flag_d = flag_q;
    if (bar_set)  flag_d = 1'b1;
    else if (ans) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/bp_mst_ctrl.sv
module bp_mst_ctrl #(
  parameter int NS = 2,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bar_acc,
  input  logic          bar_strong,
  input  logic [IW-1:0] bar_id,
  input  logic [NS-1:0] ans,
  output logic [NS-1:0] wait_mask,
  output logic          bresp_valid,
  output logic [IW-1:0] bresp_id
);
  logic [NS-1:0] mask_q, mask_d, left;
  logic          strong_q, strong_d;
  logic          resp_q, resp_d;
  logic [IW-1:0] id_q, id_d;

  assign left = mask_q & ~ans;

  always_comb begin
    mask_d   = bar_acc ? {NS{1'b1}} : left;
    strong_d = bar_acc ? bar_strong : ((left == '0) ? 1'b0 : strong_q);
    id_d     = bar_acc ? bar_id : id_q;
    resp_d   = (bar_acc && !bar_strong) ||
               (strong_q && (mask_q != '0) && (left == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      strong_q <= 1'b0;
      resp_q   <= 1'b0;
      id_q     <= '0;
    end else begin
      mask_q   <= mask_d;
      strong_q <= strong_d;
      resp_q   <= resp_d;
      if (bar_acc) id_q <= id_d;
    end
  end

  assign wait_mask   = mask_q;
  assign bresp_valid = resp_q;
  assign bresp_id    = id_q;
endmodule

// File: rtl/bar_prop.sv
module bar_prop #(
  parameter int NS      = 2,
  parameter int IW      = 4,
  parameter int AW      = 8,
  parameter int CW      = 4,
  parameter int SEL_LSB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_valid,
  output logic          m_ready,
  input  logic          m_write,
  input  logic [1:0]    m_bar,
  input  logic [IW-1:0] m_id,
  input  logic [AW-1:0] m_addr,
  output logic          m_bresp_valid,
  output logic [IW-1:0] m_bresp_id,
  output logic [NS-1:0] s_valid,
  input  logic [NS-1:0] s_ready,
  output logic          s_write,
  output logic [IW-1:0] s_id,
  output logic [AW-1:0] s_addr,
  input  logic [NS-1:0] s_done
);
  import bp_pkg::*;

  localparam int SELW = (NS > 1) ? $clog2(NS) : 1;

  logic          rst_s1, rst_q;
  logic [SELW-1:0] sel;
  logic          isbar, blocked, bar_acc;
  logic [NS-1:0] wait_mask, ans, wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  assign sel     = m_addr[SEL_LSB +: SELW];
  assign isbar   = is_barrier(m_bar);
  assign blocked = |wait_mask;
  assign m_ready = !blocked && (isbar || s_ready[sel]);
  assign bar_acc = m_valid && m_ready && isbar;

  assign s_write = m_write;
  assign s_id    = m_id;
  assign s_addr  = m_addr;

  for (genvar i = 0; i < NS; i++) begin : g_path
    assign s_valid[i] = m_valid && !isbar && !blocked && (sel == SELW'(i));
    assign wr_fire[i] = s_valid[i] && s_ready[i] && m_write;

    bp_slv_path #(.CW(CW)) u_path (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_fire (wr_fire[i]),
      .wr_done (s_done[i]),
      .bar_set (bar_acc),
      .ans     (ans[i])
    );
  end

  bp_mst_ctrl #(.NS(NS), .IW(IW)) u_mst (
    .clk         (clk),
    .rst_n       (rst_q),
    .bar_acc     (bar_acc),
    .bar_strong  (is_strong(m_bar)),
    .bar_id      (m_id),
    .ans         (ans),
    .wait_mask   (wait_mask),
    .bresp_valid (m_bresp_valid),
    .bresp_id    (m_bresp_id)
  );
endmodule

// File: rtl/bar_prop_chk.sv
module bar_prop_chk #(
  parameter int NS = 2
) (
  input logic          clk,
  input logic          rst_q,
  input logic          m_valid,
  input logic          m_ready,
  input logic [1:0]    m_bar,
  input logic [NS-1:0] s_valid,
  input logic          m_bresp_valid,
  input logic [NS-1:0] wait_mask
);
  // R2
  s_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(s_valid));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|wait_mask) |-> (!m_ready && (s_valid == '0)));

  // R4
  fanout_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (m_valid && m_ready && m_bar[0]) |=> (wait_mask == {NS{1'b1}}));

  // R7
  strong_early_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (m_valid && m_ready && (m_bar == 2'b11)) |=> !m_bresp_valid);

  // R1
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (m_valid && m_ready && (m_bar == 2'b10)) |=> (wait_mask == '0));
endmodule

bind bar_prop bar_prop_chk #(.NS(NS)) u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .m_valid       (m_valid),
  .m_ready       (m_ready),
  .m_bar         (m_bar),
  .s_valid       (s_valid),
  .m_bresp_valid (m_bresp_valid),
  .wait_mask     (wait_mask)
);

// File: tb/sim_bar_prop.sv
module sim_bar_prop;
  localparam int P  = 10;
  localparam int NS = 2;
  localparam int IW = 4;
  localparam int AW = 8;

  typedef struct packed {
    logic       mv;
    logic       mw;
    logic [1:0] bar;
    logic       sel;
    logic [3:0] id;
    logic [1:0] srdy;
    logic [1:0] sdone;
    logic       emrdy;
    logic [1:0] esval;
    logic       eb;
    logic [3:0] ebid;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,2'b00,1'b0,4'd0,2'b11,2'b00, 1'b1,2'b00,1'b0,4'd0}, // idle
    '{1'b1,1'b1,2'b00,1'b0,4'd1,2'b11,2'b00, 1'b1,2'b01,1'b0,4'd0}, // R2 write path0
    '{1'b1,1'b1,2'b00,1'b1,4'd2,2'b01,2'b00, 1'b0,2'b10,1'b0,4'd0}, // R2 path1 not ready
    '{1'b1,1'b1,2'b00,1'b1,4'd2,2'b11,2'b00, 1'b1,2'b10,1'b0,4'd0}, // R2 write path1
    '{1'b1,1'b0,2'b01,1'b0,4'd3,2'b11,2'b00, 1'b1,2'b00,1'b0,4'd0}, // R1 weak accepted
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b00, 1'b0,2'b00,1'b1,4'd3}, // R3 weak resp, R6 held
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b10, 1'b0,2'b00,1'b0,4'd0}, // R5 path1 done
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b00, 1'b0,2'b00,1'b0,4'd0}, // R5 path1 answers
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b01, 1'b0,2'b00,1'b0,4'd0}, // R5 path0 done
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b00, 1'b0,2'b00,1'b0,4'd0}, // R6 last answer
    '{1'b1,1'b0,2'b00,1'b0,4'd4,2'b11,2'b00, 1'b1,2'b01,1'b0,4'd0}, // R6 released
    '{1'b1,1'b0,2'b11,1'b0,4'd5,2'b11,2'b00, 1'b1,2'b00,1'b0,4'd0}, // R1 strong accepted
    '{1'b1,1'b1,2'b00,1'b0,4'd6,2'b11,2'b00, 1'b0,2'b00,1'b0,4'd0}, // R4 both answer, R7 none yet
    '{1'b1,1'b1,2'b00,1'b0,4'd6,2'b11,2'b00, 1'b1,2'b01,1'b1,4'd5}, // R7 strong resp
    '{1'b1,1'b1,2'b10,1'b1,4'd7,2'b11,2'b00, 1'b1,2'b10,1'b0,4'd0}, // R1 reserved as write
    '{1'b1,1'b0,2'b11,1'b0,4'd9,2'b11,2'b00, 1'b1,2'b00,1'b0,4'd0}, // strong accepted
    '{1'b1,1'b0,2'b01,1'b0,4'd8,2'b11,2'b10, 1'b0,2'b00,1'b0,4'd0}, // R8 second barrier held
    '{1'b1,1'b0,2'b01,1'b0,4'd8,2'b11,2'b00, 1'b0,2'b00,1'b0,4'd0}, // R8 still held
    '{1'b0,1'b0,2'b00,1'b0,4'd0,2'b11,2'b01, 1'b0,2'b00,1'b0,4'd0}, // R7 no early resp
    '{1'b0,1'b0,2'b00,1'b0,4'd0,2'b11,2'b00, 1'b0,2'b00,1'b0,4'd0}, // R5 path0 answers
    '{1'b0,1'b0,2'b00,1'b0,4'd0,2'b11,2'b00, 1'b1,2'b00,1'b1,4'd9}, // R7 resp after last
    '{1'b0,1'b0,2'b00,1'b0,4'd0,2'b11,2'b00, 1'b1,2'b00,1'b0,4'd0}  // R8 rejected one gave none
  };

  logic          clk, rst_n;
  logic          m_valid, m_ready, m_write;
  logic [1:0]    m_bar;
  logic [IW-1:0] m_id;
  logic [AW-1:0] m_addr;
  logic          m_bresp_valid;
  logic [IW-1:0] m_bresp_id;
  logic [NS-1:0] s_valid, s_ready, s_done;
  logic          s_write;
  logic [IW-1:0] s_id;
  logic [AW-1:0] s_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  bar_prop u0 (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_bar(m_bar), .m_id(m_id), .m_addr(m_addr),
    .m_bresp_valid(m_bresp_valid), .m_bresp_id(m_bresp_id),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write),
    .s_id(s_id), .s_addr(s_addr), .s_done(s_done)
  );

  initial clk = 1'b0;
  always #(P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic mv, input logic mw, input logic [1:0] bar,
                       input logic sel, input logic [3:0] id,
                       input logic [1:0] srdy, input logic [1:0] sdone);
    m_valid = mv; m_write = mw; m_bar = bar; m_id = id;
    m_addr = {sel, 7'd0}; s_ready = srdy; s_done = sdone;
  endtask

  initial begin
    #(P*5000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 2'b00, 0, 0, 2'b11, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset no resp", m_bresp_valid, 0);
    chk("R9 reset not blocked", m_ready, 1);

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      drive(TBL[r].mv, TBL[r].mw, TBL[r].bar, TBL[r].sel, TBL[r].id,
            TBL[r].srdy, TBL[r].sdone);
      #1;
      chk($sformatf("R2 R6 R8 m_ready row %0d", r), m_ready, TBL[r].emrdy);
      chk($sformatf("R2 s_valid row %0d", r), s_valid, TBL[r].esval);
      chk($sformatf("R3 R7 bresp row %0d", r), m_bresp_valid, TBL[r].eb);
      if (TBL[r].eb)
        chk($sformatf("R3 bresp id row %0d", r), m_bresp_id, TBL[r].ebid);
    end

    // R9: reset in the middle of a barrier wait
    @(negedge clk); drive(1, 1, 2'b00, 0, 1, 2'b11, 2'b00);
    @(negedge clk); drive(1, 0, 2'b11, 0, 4'd2, 2'b11, 2'b00);
    @(negedge clk); drive(0, 0, 2'b00, 0, 0, 2'b11, 2'b00);
    #1 chk("R9 blocked before reset", m_ready, 0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R9 async clear unblocks", m_ready, 1);
    chk("R9 async clear resp", m_bresp_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1, 0, 2'b11, 0, 4'd7, 2'b11, 2'b00);
    #1 chk("R9 barrier accepted", m_ready, 1);
    @(negedge clk); drive(0, 0, 2'b00, 0, 0, 2'b11, 2'b00);
    #1 chk("R9 R7 no early resp", m_bresp_valid, 0);
    @(negedge clk);
    #1;
    chk("R9 count cleared resp", m_bresp_valid, 1);
    chk("R9 resp id", m_bresp_id, 7);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule